// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Pin Override

This block is an eight-pin general-purpose I/O port with a small register bus. Software sees three byte registers: an output latch (offset 0x18), a read-only view of the synchronized pin levels (offset 0x19) and a per-pin direction register (offset 0x1A). Each pin leaves the block as an output-enable and an output value, ready for a pad cell.

Two on-chip peripherals can take a pin away from software. A PWM unit forces any pin whose channel is enabled to be an output carrying the PWM waveform. Its top channel also has a shutdown feature that forces that pin to be an input. An SPI unit, when enabled, sets both direction and value on the low four pins. When a peripheral lets go of a pin, the direction register and output latch take it back in the same cycle. Pin levels pass through a two-flop synchronizer clocked by the bus clock before software can read them. Software can therefore compare the levels it reads against the values it drives and detect a pin held at the wrong level.

Top module: `pio_port`

## Requirements
- R1: A write to offset 0x19 changes nothing: the output latch and the direction register keep their values.
- R2: A read of offset 0x19 returns the synchronized level of every pin, whatever the pin's direction.
- R3: The direction register at offset 0x1A can be read and written at any time and reads 0x00 after reset, so `pad_oe` is 0x00 after reset.
- R4: With no peripheral override, bit i of `pad_oe` equals direction bit i (1 = output, 0 = input), and bit i of `pad_out` equals output-latch bit i.
- R5: When `pwm_en[i]` is 1 and no higher-priority override applies, `pad_oe[i]` is 1 and `pad_out[i]` equals `pwm_out[i]`, whatever the direction register holds.
- R6: When `pwm_shut_en` is 1, `pad_oe[7]` is 0 and `pad_out[7]` is 0, whatever `pwm_en[7]` and direction bit 7 hold.
- R7: When `spi_en` is 1, each pin in the SPI mask (pins 0 to 3, mask 0x0F) takes `pad_oe` from `spi_oe` and `pad_out` from `spi_out`, and its direction bit is ignored.
- R8: When a PWM channel or the SPI unit is disabled, its pins return to the direction register and output latch in the same cycle.
- R9: A change on `pad_in` appears in the register reads after exactly two rising clock edges and not after one.
- R10: The override priority per pin is: shutdown (pin 7 only), then PWM enable, then SPI (masked pins only), then the direction register.
- R11: The output latch at offset 0x18 is writable and resets to 0x00. A read returns the latch bit on pins whose direction bit is 1 and the synchronized pin level on pins whose direction bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when no read is selected |
| pwm_en | input | 8 | Per-channel PWM enables |
| pwm_out | input | 8 | Per-channel PWM waveforms |
| pwm_shut_en | input | 1 | PWM top-channel shutdown enable, forces pin 7 to input |
| spi_en | input | 1 | SPI unit enabled |
| spi_oe | input | 8 | SPI-requested direction per pin (only masked pins used) |
| spi_out | input | 8 | SPI-requested output value per pin (only masked pins used) |
| pad_in | input | 8 | Raw, asynchronous pin levels |
| pad_out | output | 8 | Resolved output value per pin |
| pad_oe | output | 8 | Resolved output enable per pin |

## Verification
The bench sweeps every direction value and every PWM enable pattern against fixed latch and waveform values. A design that fell back to the direction register too early, or mixed the PWM waveform into the wrong pins, shows a wrong `pad_oe` or `pad_out` byte. It enables shutdown with every override active, so a design that let PWM beat shutdown leaves pin 7 driven. It turns on SPI with PWM active on a masked pin, which catches a wrong ordering between those two. It samples reads one edge and two edges after a pin change, so a design with one synchronizer stage or three shows up. It also writes the input register and mixes directions in the data readback, to catch address aliasing and a readback that selects the wrong source.

// File: rtl/pio_port_pkg.sv
// Package: shared offsets and override source type for the I/O port.
// Assumes an 8-bit register offset space.
package pio_port_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_LATCH = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h19;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h1A;

    // Which agent owns a pin after priority resolution.
    typedef enum logic [1:0] {
        SRC_SOFT = 2'd0,
        SRC_SPI  = 2'd1,
        SRC_PWM  = 2'd2,
        SRC_SHUT = 2'd3
    } pin_src_e;

    // Ordered pick of the owning agent for one pin.
    function automatic pin_src_e pick_src(input logic shut, input logic pwm,
                                          input logic spi);
        if (shut)     return SRC_SHUT;
        else if (pwm) return SRC_PWM;
        else if (spi) return SRC_SPI;
        else          return SRC_SOFT;
    endfunction
endpackage

// File: rtl/pio_sync.sv
// Module: multi-stage level synchronizer, one chain per pin.
// Assumes the pin levels are asynchronous to clk; resets the chain to zero.
module pio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of every pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                // Later stages shift the captured level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] age_q;
            // Count edges since reset, saturating at two, to qualify the lag check.
            always_ff @(posedge clk) begin
                if (!rst_n)             age_q <= 2'd0;
                else if (age_q != 2'd2) age_q <= age_q + 2'd1;
            end
            p_two_edge_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
        end
    endgenerate
endmodule

// File: rtl/pio_regs.sv
// Module: software registers (output latch, direction) and read multiplexer.
// Assumes single-cycle accesses; reads are combinational.
module pio_regs
    import pio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  level_i,
    output logic [WIDTH-1:0]  latch_o,
    output logic [WIDTH-1:0]  dir_o
);
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic             wr_latch;
    logic             wr_dir;

    assign wr_latch = bus_sel && bus_wr && (bus_addr == OFS_LATCH);
    assign wr_dir   = bus_sel && bus_wr && (bus_addr == OFS_DIR);

    // Output latch update.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= bus_wdata;
    end

    // Direction register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= bus_wdata;
    end

    // Read multiplexer; the latch view mixes driven and sampled bits.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFS_LATCH: bus_rdata = (latch_q & dir_q) | (level_i & ~dir_q);
                OFS_LEVEL: bus_rdata = level_i;
                OFS_DIR:   bus_rdata = dir_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;

    p_level_write_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_LEVEL) |=> ($stable(latch_q) && $stable(dir_q)));
    p_dir_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));
    p_latch_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_LATCH) |=> (latch_q == $past(bus_wdata)));
endmodule

// File: rtl/pio_pin_mux.sv
// Module: per-pin ownership resolution between shutdown, PWM, SPI and software.
// Assumes peripheral inputs are synchronous to clk; purely combinational.
module pio_pin_mux
    import pio_port_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] SPI_MASK = 8'h0F,
    parameter int               SHUT_PIN = WIDTH - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] latch_i,
    input  logic [WIDTH-1:0] pwm_en,
    input  logic [WIDTH-1:0] pwm_out,
    input  logic             pwm_shut_en,
    input  logic             spi_en,
    input  logic [WIDTH-1:0] spi_oe,
    input  logic [WIDTH-1:0] spi_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            pin_src_e src;
            logic     shut_here;
            logic     spi_here;

            assign shut_here = (i == SHUT_PIN) && pwm_shut_en;
            assign spi_here  = spi_en && SPI_MASK[i];
            assign src       = pick_src(shut_here, pwm_en[i], spi_here);

            // Drive enable and value from the owning agent.
            always_comb begin
                unique case (src)
                    SRC_SHUT: begin pad_oe[i] = 1'b0;      pad_out[i] = 1'b0;       end
                    SRC_PWM:  begin pad_oe[i] = 1'b1;      pad_out[i] = pwm_out[i]; end
                    SRC_SPI:  begin pad_oe[i] = spi_oe[i]; pad_out[i] = spi_out[i]; end
                    default:  begin pad_oe[i] = dir_i[i];  pad_out[i] = latch_i[i]; end
                endcase
            end

            p_pwm_forces_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pwm_en[i] && !shut_here) |-> (pad_oe[i] && pad_out[i] == pwm_out[i]));
            p_soft_owns_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!pwm_en[i] && !shut_here && !spi_here) |-> (pad_oe[i] == dir_i[i]));
        end
    endgenerate
endmodule

// File: rtl/pio_port.sv
// Module: top of the eight-pin I/O port with peripheral override.
// Assumes synchronous active-low reset and single-cycle register accesses.
module pio_port
    import pio_port_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] SPI_MASK    = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pwm_en,
    input  logic [WIDTH-1:0]  pwm_out,
    input  logic              pwm_shut_en,
    input  logic              spi_en,
    input  logic [WIDTH-1:0]  spi_oe,
    input  logic [WIDTH-1:0]  spi_out,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    localparam int SHUT_PIN = WIDTH - 1;

    logic [WIDTH-1:0] level;
    logic [WIDTH-1:0] latch;
    logic [WIDTH-1:0] dir;

    pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pad_in),
        .sync_o (level)
    );

    pio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level_i   (level),
        .latch_o   (latch),
        .dir_o     (dir)
    );

    pio_pin_mux #(.WIDTH(WIDTH), .SPI_MASK(SPI_MASK), .SHUT_PIN(SHUT_PIN)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .dir_i       (dir),
        .latch_i     (latch),
        .pwm_en      (pwm_en),
        .pwm_out     (pwm_out),
        .pwm_shut_en (pwm_shut_en),
        .spi_en      (spi_en),
        .spi_oe      (spi_oe),
        .spi_out     (spi_out),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out)
    );

    p_shutdown_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_shut_en |-> (!pad_oe[SHUT_PIN] && !pad_out[SHUT_PIN]));
    p_spi_beats_soft_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && SPI_MASK[0] && !pwm_en[0]) |-> (pad_oe[0] == spi_oe[0]));
    p_level_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_LEVEL) |-> (bus_rdata == level));
endmodule

// File: tb/pio_port_tb.sv
// Bench: sweeps of direction, PWM and SPI settings with arithmetic expectations.
module pio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pwm_en = '0, pwm_out = '0;
    logic       pwm_shut_en = 1'b0, spi_en = 1'b0;
    logic [7:0] spi_oe = '0, spi_out = '0, pad_in = '0;
    logic [7:0] pad_out, pad_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_en(pwm_en), .pwm_out(pwm_out), .pwm_shut_en(pwm_shut_en),
        .spi_en(spi_en), .spi_oe(spi_oe), .spi_out(spi_out),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] exp_oe, exp_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        rd(8'h1A, v); check("R3 dir reset", v, 8'h00);
        #1 check("R3 oe after reset", pad_oe, 8'h00);
        rd(8'h18, v); check("R11 latch reset (all inputs, pins low)", v, 8'h00);

        // R3/R4: every direction value, no overrides
        wr(8'h18, 8'h96);
        for (int d = 0; d < 256; d++) begin
            wr(8'h1A, d[7:0]);
            rd(8'h1A, v); check("R3 dir readback", v, d[7:0]);
            check("R4 oe follows dir", pad_oe, d[7:0]);
            check("R4 out follows latch", pad_out, 8'h96);
        end

        // R11: mixed readback of the latch register
        wr(8'h1A, 8'hF0); wr(8'h18, 8'hA5);
        @(negedge clk); pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        rd(8'h18, v); check("R11 mixed latch read", v, 8'hAC);

        // R2: level register returns pins regardless of direction
        rd(8'h19, v); check("R2 level read", v, 8'h3C);

        // R1: write to the level register leaves latch and dir alone
        wr(8'h19, 8'h5A);
        rd(8'h1A, v); check("R1 dir unchanged", v, 8'hF0);
        wr(8'h1A, 8'hFF);
        rd(8'h18, v); check("R1 latch unchanged", v, 8'hA5);

        // R9: two-edge lag, several patterns
        foreach (v[k]) begin end
        for (int p = 0; p < 8; p++) begin
            logic [7:0] old_v, new_v;
            old_v = pad_in;
            new_v = 8'h5D ^ (8'h27 * p[7:0]);
            if (new_v == old_v) new_v = ~old_v;
            @(negedge clk); pad_in = new_v;
            rd(8'h19, v); check("R9 one edge still old", v, old_v);
            rd(8'h19, v); check("R9 two edges new", v, new_v);
            wr(8'h1A, 8'h00);
            rd(8'h18, v); check("R2 level on inputs", v, new_v);
        end

        // R5/R8: every PWM enable pattern
        wr(8'h18, 8'h33); wr(8'h1A, 8'h5A);
        @(negedge clk); pwm_out = 8'hC6;
        for (int p = 0; p < 256; p++) begin
            @(negedge clk); pwm_en = p[7:0];
            #1;
            exp_oe  = p[7:0] | 8'h5A;
            exp_out = (p[7:0] & 8'hC6) | (~p[7:0] & 8'h33);
            check("R5 pwm oe", pad_oe, exp_oe);
            check("R5 pwm out", pad_out, exp_out);
        end
        @(negedge clk); pwm_en = 8'h00; #1;
        check("R8 pwm release oe", pad_oe, 8'h5A);
        check("R8 pwm release out", pad_out, 8'h33);

        // R6/R10: shutdown beats PWM and dir
        wr(8'h1A, 8'hFF);
        @(negedge clk); pwm_en = 8'hFF; pwm_out = 8'hFF; pwm_shut_en = 1'b1; #1;
        check("R6 shutdown oe", pad_oe, 8'h7F);
        check("R6 shutdown out", pad_out, 8'h7F);
        @(negedge clk); pwm_shut_en = 1'b0; #1;
        check("R10 shutdown released", pad_oe, 8'hFF);
        @(negedge clk); pwm_en = 8'h00; pwm_shut_en = 1'b1; #1;
        check("R6 shutdown over dir", pad_oe, 8'h7F);
        @(negedge clk); pwm_shut_en = 1'b0;

        // R7: SPI sweep over masked-pin direction and values
        wr(8'h1A, 8'hA5); wr(8'h18, 8'h0F);
        @(negedge clk); spi_en = 1'b1;
        for (int s = 0; s < 256; s++) begin
            @(negedge clk); spi_oe = s[7:0]; spi_out = ~s[7:0]; #1;
            check("R7 spi oe", pad_oe, (8'hA5 & 8'hF0) | (s[7:0] & 8'h0F));
            check("R7 spi out", pad_out, (8'h0F & 8'hF0) | (~s[7:0] & 8'h0F));
        end

        // R10: PWM on a masked pin beats SPI
        @(negedge clk); spi_oe = 8'h00; spi_out = 8'h00; pwm_en = 8'h02; pwm_out = 8'h02; #1;
        check("R10 pwm over spi oe", pad_oe, 8'hA2);
        check("R10 pwm over spi out", pad_out, 8'h02);

        // R8: SPI release hands pins back
        @(negedge clk); pwm_en = 8'h00; spi_en = 1'b0; #1;
        check("R8 spi release oe", pad_oe, 8'hA5);
        check("R8 spi release out", pad_out, 8'h0F);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule